// File: doc/BRIEF.md
# Protected Register Write Guard

This block holds one critical control word, for example a clock-source selection, together with a small status register. It sits on a single-cycle peripheral bus. Software cannot change the control word with an ordinary store. It must first store any value to a dedicated command address, which arms a one-shot unlock. The store to the guarded address must then be the very next bus access. If anything happens in between, the guarded store is dropped and a sticky error flag is raised. That includes another access, a transfer from a second bus master, or an acknowledged interrupt.

After an accepted update, a settle counter holds a busy output high for a fixed number of clock cycles. Downstream logic uses this to wait before it relies on the new setting. Reads of the guarded word are always allowed, and they do not consume the unlock.

Top module: `prot_wr_guard`

## Requirements
- R1: After reset, the guarded word equals RESET_VAL (default 0x00), the unlock is not armed, the error flag is 0 and `settle_busy` is low.
- R2: A write of any data to the command address (default 1'h0 offset 0) arms the unlock. A write to the guarded address (offset 1) made as the next bus access loads the guarded word with the write data.
- R3: An `irq_ack` pulse in any cycle after the command write, up to and including the guarded write's cycle, cancels the unlock. The guarded write is then discarded and the error flag is set.
- R4: A write to the guarded address while the unlock is not armed leaves the guarded word unchanged and sets the error flag.
- R5: Any intervening access cancels the unlock. This includes a `bus_ext` access from another master, a write to any other address, and a read of any address other than the guarded one. A following guarded write is then rejected as in R4.
- R6: Reads of the guarded address return the guarded word at any time, and they leave the armed state unchanged.
- R7: The error flag is sticky. It clears only on a write to the status address (offset 2) with bit 0 = 0. Writing bit 0 = 1 or performing an accepted guarded write does not clear it.
- R8: After an accepted guarded write, `settle_busy` is high for exactly SETTLE (default 5) cycles, starting the cycle after the write. Another accepted write during that window restarts the full count.
- R9: The status register reads bit 0 = error flag, bit 1 = armed, bit 2 = settle busy, and all other bits 0. Unmapped addresses read 0. `bus_rdata` is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | DW | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_ext | input | 1 | Access by another bus master in this cycle |
| irq_ack | input | 1 | Interrupt acknowledged in this cycle |
| bus_rdata | output | DW | Read data for `bus_addr` |
| prot_value | output | DW | Current guarded word |
| settle_busy | output | 1 | High while the new setting settles |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is an interrupt acknowledge and the guarded write itself. The bench drives `irq_ack` in the same cycle as the write that follows a valid command write. It then judges that the word is unchanged and the error flag set. The second pair is the settle window and a fresh accepted write. The bench issues a second unlocked write while busy is still counting, and expects busy to last a full SETTLE cycles from the later write rather than the earlier one.

// File: rtl/prot_wr_guard.sv
module prot_wr_guard #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] RESET_VAL = '0,
  parameter int SETTLE = 5,
  parameter int CMD_ADDR = 0,
  parameter int TGT_ADDR = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_ext,
  input  logic          irq_ack,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] prot_value,
  output logic          settle_busy
);
  localparam int CW = $clog2(SETTLE + 1);

  logic          armed_q, err_q;
  logic [DW-1:0] value_q;
  logic [CW-1:0] cnt_q;

  wire hit_cmd  = bus_addr == AW'(CMD_ADDR);
  wire hit_tgt  = bus_addr == AW'(TGT_ADDR);
  wire hit_stat = bus_addr == AW'(STAT_ADDR);

  wire cmd_wr  = bus_wr & hit_cmd;
  wire tgt_wr  = bus_wr & hit_tgt;
  wire stat_wr = bus_wr & hit_stat;
  wire quiet   = ~irq_ack & ~bus_ext;
  wire grant   = tgt_wr & armed_q & quiet;
  wire breaker = ~quiet | (bus_wr & ~hit_cmd) | (bus_rd & ~hit_tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
      value_q <= RESET_VAL;
      cnt_q   <= '0;
    end else begin
      if (cmd_wr && quiet)   armed_q <= 1'b1;
      else if (breaker)      armed_q <= 1'b0;

      if (tgt_wr && !grant)                 err_q <= 1'b1;
      else if (stat_wr && !bus_wdata[0])    err_q <= 1'b0;

      if (grant) begin
        value_q <= bus_wdata;
        cnt_q   <= CW'(SETTLE);
      end else if (cnt_q != '0) begin
        cnt_q   <= cnt_q - 1'b1;
      end
    end
  end

  assign prot_value  = value_q;
  assign settle_busy = cnt_q != '0;

  always_comb begin
    bus_rdata = '0;
    if (hit_tgt)       bus_rdata = value_q;
    else if (hit_stat) bus_rdata = {{(DW-3){1'b0}}, settle_busy, armed_q, err_q};
  end

  p_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && armed_q && quiet) |=> prot_value == $past(bus_wdata));

  p_irq_voids_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !armed_q);

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && !armed_q) |=> (err_q && $stable(prot_value)));

  p_ext_voids_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ext |=> !armed_q);

  p_tgt_read_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_tgt && quiet) |=> $stable(armed_q));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(stat_wr && !bus_wdata[0])) |=> err_q);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> settle_busy);

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && !grant) |=> !settle_busy);
endmodule

// File: tb/prot_wr_guard_bench.sv
module prot_wr_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_ext = 1'b0, irq_ack = 1'b0;
  logic [7:0] bus_rdata, prot_value;
  logic       settle_busy;
  logic       mon_go = 1'b0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct { bit is_busy; logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  prot_wr_guard u_prot_wr_guard (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ext(bus_ext), .irq_ack(irq_ack),
    .bus_rdata(bus_rdata), .prot_value(prot_value), .settle_busy(settle_busy));

  always @(negedge clk) begin
    #2;
    if (mon_go && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_busy ? {7'd0, settle_busy} : bus_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic drive(bit wr, bit rd, bit ext, bit irq, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_ext = ext; irq_ack = irq;
    bus_addr = a; bus_wdata = d; mon_go = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 4'd0, 8'h00);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d); drive(1, 0, 0, 0, a, d); endtask

  task automatic rd_chk(logic [3:0] a, logic [7:0] e, string tag);
    drive(0, 1, 0, 0, a, 8'h00);
    q.push_back('{1'b0, e, tag});
    mon_go = 1'b1;
  endtask

  task automatic busy_chk(bit e, string tag);
    drive(0, 0, 0, 0, 4'd0, 8'h00);
    q.push_back('{1'b1, {7'd0, e}, tag});
    mon_go = 1'b1;
  endtask

  task automatic clr_err(); wr(4'd2, 8'h00); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    rd_chk(4'd1, 8'h00, "R1 reset value");
    rd_chk(4'd2, 8'h00, "R1 reset status");
    busy_chk(0, "R1 reset busy");

    wr(4'd0, 8'hA5);
    wr(4'd1, 8'h3C);
    for (int i = 0; i < 5; i++) busy_chk(1, "R8 settle window");
    busy_chk(0, "R8 settle end");
    rd_chk(4'd1, 8'h3C, "R2 unlocked write");
    rd_chk(4'd2, 8'h00, "R2 no error");

    wr(4'd1, 8'h11);
    rd_chk(4'd1, 8'h3C, "R4 direct write ignored");
    rd_chk(4'd2, 8'h01, "R4 error set");
    wr(4'd2, 8'h01);
    rd_chk(4'd2, 8'h01, "R7 write one keeps");
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h55);
    rd_chk(4'd1, 8'h55, "R2 zero command data");
    rd_chk(4'd2, 8'h05, "R7 R9 error kept with busy");
    clr_err();
    idle(6);
    rd_chk(4'd2, 8'h00, "R7 cleared");

    wr(4'd0, 8'hFF);
    drive(0, 0, 0, 1, 4'd0, 8'h00);
    wr(4'd1, 8'h77);
    rd_chk(4'd1, 8'h55, "R3 irq between");
    rd_chk(4'd2, 8'h01, "R3 error");
    clr_err();

    wr(4'd0, 8'h12);
    drive(1, 0, 0, 1, 4'd1, 8'h78);
    rd_chk(4'd1, 8'h55, "R3 irq same cycle");
    rd_chk(4'd2, 8'h01, "R3 error same cycle");
    clr_err();

    wr(4'd0, 8'h34);
    drive(0, 0, 1, 0, 4'd3, 8'h00);
    wr(4'd1, 8'h79);
    rd_chk(4'd1, 8'h55, "R5 other master");
    rd_chk(4'd2, 8'h01, "R5 error");
    clr_err();

    wr(4'd0, 8'h56);
    rd_chk(4'd2, 8'h02, "R9 armed bit");
    wr(4'd1, 8'h7A);
    rd_chk(4'd1, 8'h55, "R5 status read voids");
    clr_err();

    wr(4'd0, 8'h9A);
    rd_chk(4'd1, 8'h55, "R6 read while armed");
    rd_chk(4'd2, 8'h02, "R6 still armed");
    wr(4'd0, 8'h9A);
    rd_chk(4'd1, 8'h55, "R6 read value");
    wr(4'd1, 8'h99);
    rd_chk(4'd1, 8'h99, "R6 write after read");
    rd_chk(4'd2, 8'h04, "R9 busy bit");
    idle(6);

    wr(4'd0, 8'h01);
    wr(4'd1, 8'h01);
    busy_chk(1, "R8 first window");
    busy_chk(1, "R8 first window");
    wr(4'd0, 8'h02);
    wr(4'd1, 8'h02);
    for (int i = 0; i < 5; i++) busy_chk(1, "R8 reload window");
    busy_chk(0, "R8 reload end");
    rd_chk(4'd1, 8'h02, "R2 second value");
    rd_chk(4'd3, 8'h00, "R9 unmapped reads zero");
    rd_chk(4'd2, 8'h00, "R7 no spurious error");

    idle(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule